// File: doc/BRIEF.md
# Set-Associative Cache Tag Directory

This block holds the address side of a four-way cache whose lines are 16 bytes (four 32-bit words). For each access it cuts the 32-bit address into a byte offset, a set index and a 22-bit tag. It reads the four stored tags of the selected set, compares them with the tag of the access, and reports whether exactly one valid way matched and which way it was. Each stored entry keeps a valid flag and a modified (dirty) flag next to its tag.

One operation port carries two kinds of operation: lookups and fills. A lookup that is a write and hits marks the line modified, unless the access asks for write-through. A fill loads a new tag into a victim way. The victim way is chosen outside the block and given as an input. If the victim holds a valid modified line, the block reports that line's tag and set so the line can be copied out. The directory can work with 256 or 512 sets, and a mode register that comes out of reset in the 256-set setting picks between them. An invalidate-all command sweeps the sets one per clock and shows busy until the sweep is done.

The tag store is one simple dual-port memory per way, so block RAM can be inferred for it. The valid and modified flags live in flip-flops so that reset and the sweep can clear them. Every result appears on registered outputs two clock edges after the operation is taken.

Top module: `cache_tag_dir`

## Requirements
- R1: Address bits 3:0 do not affect any result. The set index is bits 11:4 when the mode register holds 0 (256 sets) and bits 12:4 when it holds 1 (512 sets). The stored and compared tag is always bits 31:10.
- R2: After reset the mode register is 0, every entry is invalid and not modified, and rsp_valid, rsp_hit, rsp_multi, wb_req and busy are 0.
- R3: A lookup taken at edge N (op_valid=1, op_fill=0, busy=0) raises rsp_valid for one cycle after edge N+1. rsp_hit is 1 only when exactly one valid way holds the tag, and rsp_way then gives that way as a binary number from 0 to 3.
- R4: When more than one valid way of the set holds the tag, the response shows rsp_multi=1 and rsp_hit=0.
- R5: A lookup with op_write=1 and op_wt=0 that hits sets the modified flag of the hit way. A read lookup, or a write lookup with op_wt=1, leaves the flag unchanged.
- R6: A fill to way op_way stores the tag and sets valid. It sets the modified flag only when op_write=1 and op_wt=0, and clears it otherwise.
- R7: A fill taken at edge N raises wb_req after edge N+1 if and only if the victim way was valid and modified. When it does, wb_tag carries the tag held before the fill and wb_index carries the set index (zero-extended in the 256-set mode).
- R8: When busy=0, inv_start raises busy at the next edge. busy then stays high for exactly 512 cycles, and afterwards every entry in both modes is invalid and not modified.
- R9: An operation offered while busy=1 is ignored: it gives no response, no write-back report and no change to any entry.
- R10: cfg_we=1 loads cfg_big into the mode register at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Load the set-count mode register |
| cfg_big | input | 1 | Mode value: 1 selects 512 sets, 0 selects 256 |
| inv_start | input | 1 | Start the invalidate-all sweep |
| busy | output | 1 | Sweep in progress |
| op_valid | input | 1 | Operation offered this cycle |
| op_fill | input | 1 | 1 = fill, 0 = lookup |
| op_write | input | 1 | Access is a write |
| op_wt | input | 1 | Access uses write-through (1) or write-back (0) |
| op_addr | input | 32 | Byte address of the access |
| op_way | input | 2 | Victim way for a fill |
| rsp_valid | output | 1 | Lookup result present |
| rsp_hit | output | 1 | Exactly one valid way matched |
| rsp_way | output | 2 | Way that hit |
| rsp_multi | output | 1 | More than one valid way matched |
| wb_req | output | 1 | Modified victim must be written back |
| wb_tag | output | 22 | Tag of the victim line |
| wb_index | output | 9 | Set index of the victim line |

## Verification
The bound assertions assume that operations arrive no closer than every other cycle. This lets each update land before the next read of the same set. They also assume that inv_start never arrives in the same cycle as an operation or while an earlier operation is still in the pipeline. With those rules kept, a response or write-back report can only follow an operation taken two edges earlier while busy was low, and a sweep always lasts exactly the set count. The bench drives each operation for a single cycle and then leaves one idle cycle. It starts every sweep only after the previous response has been sampled, and the only operations it offers during a sweep are the ones that are meant to be dropped.

// File: rtl/cache_tag_pkg.sv
package cache_tag_pkg;
  localparam int unsigned ADDR_W = 32;
  localparam int unsigned TAG_W  = 22;
  localparam int unsigned OFF_W  = 4;
  localparam int unsigned IDX_W  = 9;
  localparam int unsigned WAYS   = 4;
endpackage

// File: rtl/cache_tag_way.sv
module cache_tag_way #(
  parameter int unsigned TAG_W = 22,
  parameter int unsigned IDX_W = 9,
  localparam int unsigned SETS = 1 << IDX_W
)(
  input  logic             clk,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [TAG_W-1:0] rd_tag,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [TAG_W-1:0] mem [SETS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_tag;
    if (rd_en) rd_tag <= mem[rd_idx];
  end
endmodule

// File: rtl/cache_tag_state.sv
module cache_tag_state #(
  parameter int unsigned WAYS  = 4,
  parameter int unsigned IDX_W = 9,
  localparam int unsigned SETS  = 1 << IDX_W,
  localparam int unsigned WAY_W = $clog2(WAYS)
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             rd_en,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [WAYS-1:0]  rd_vld,
  output logic [WAYS-1:0]  rd_drt,
  input  logic             inv_start,
  output logic             busy,
  input  logic             upd_en,
  input  logic [IDX_W-1:0] upd_idx,
  input  logic [WAY_W-1:0] upd_way,
  input  logic             upd_fill,
  input  logic             upd_dirty
);
  logic [WAYS-1:0]  vld [SETS];
  logic [WAYS-1:0]  drt [SETS];
  logic [IDX_W-1:0] sweep;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      sweep  <= '0;
      rd_vld <= '0;
      rd_drt <= '0;
      for (int i = 0; i < SETS; i++) begin
        vld[i] <= '0;
        drt[i] <= '0;
      end
    end else begin
      if (busy) begin
        vld[sweep] <= '0;
        drt[sweep] <= '0;
        sweep      <= sweep + 1'b1;
        if (sweep == IDX_W'(SETS - 1)) busy <= 1'b0;
      end else if (inv_start) begin
        busy  <= 1'b1;
        sweep <= '0;
      end else if (upd_en) begin
        if (upd_fill) begin
          vld[upd_idx][upd_way] <= 1'b1;
          drt[upd_idx][upd_way] <= upd_dirty;
        end else if (upd_dirty) begin
          drt[upd_idx][upd_way] <= 1'b1;
        end
      end
      if (rd_en) begin
        rd_vld <= vld[rd_idx];
        rd_drt <= drt[rd_idx];
      end
    end
  end
endmodule

// File: rtl/cache_tag_dir.sv
module cache_tag_dir #(
  parameter int unsigned ADDR_W = cache_tag_pkg::ADDR_W,
  parameter int unsigned TAG_W  = cache_tag_pkg::TAG_W,
  parameter int unsigned OFF_W  = cache_tag_pkg::OFF_W,
  parameter int unsigned IDX_W  = cache_tag_pkg::IDX_W,
  parameter int unsigned WAYS   = cache_tag_pkg::WAYS,
  localparam int unsigned WAY_W = $clog2(WAYS)
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic              cfg_big,
  input  logic              inv_start,
  output logic              busy,
  input  logic              op_valid,
  input  logic              op_fill,
  input  logic              op_write,
  input  logic              op_wt,
  input  logic [ADDR_W-1:0] op_addr,
  input  logic [WAY_W-1:0]  op_way,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [WAY_W-1:0]  rsp_way,
  output logic              rsp_multi,
  output logic              wb_req,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [IDX_W-1:0]  wb_index
);
  logic             big_q;
  logic             accept;
  logic [IDX_W-1:0] idx0;
  logic             unused_offset;

  logic             s1_valid, s1_fill, s1_write, s1_wt;
  logic [IDX_W-1:0] s1_idx;
  logic [TAG_W-1:0] s1_tag;
  logic [WAY_W-1:0] s1_way;

  logic [TAG_W-1:0] way_tag [WAYS];
  logic [WAYS-1:0]  row_vld, row_drt, match;
  logic             single, multi;
  logic [WAY_W-1:0] hit_enc;
  logic             upd_en, upd_dirty;
  logic [WAY_W-1:0] upd_way;

  assign unused_offset = ^op_addr[OFF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)         big_q <= 1'b0;
    else if (cfg_we) big_q <= cfg_big;
  end

  assign accept = op_valid & ~busy;
  assign idx0   = big_q ? op_addr[OFF_W +: IDX_W]
                        : {1'b0, op_addr[OFF_W +: IDX_W-1]};

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_fill  <= 1'b0;
      s1_write <= 1'b0;
      s1_wt    <= 1'b0;
      s1_idx   <= '0;
      s1_tag   <= '0;
      s1_way   <= '0;
    end else begin
      s1_valid <= accept;
      if (accept) begin
        s1_fill  <= op_fill;
        s1_write <= op_write;
        s1_wt    <= op_wt;
        s1_idx   <= idx0;
        s1_tag   <= op_addr[ADDR_W-1 -: TAG_W];
        s1_way   <= op_way;
      end
    end
  end

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    cache_tag_way #(.TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
      .clk    (clk),
      .rd_en  (accept),
      .rd_idx (idx0),
      .rd_tag (way_tag[w]),
      .wr_en  (s1_valid & s1_fill & (s1_way == WAY_W'(w))),
      .wr_idx (s1_idx),
      .wr_tag (s1_tag)
    );
    assign match[w] = row_vld[w] & (way_tag[w] == s1_tag);
  end

  assign single = (match != '0) && ((match & (match - 1'b1)) == '0);
  assign multi  = (match != '0) && !single;

  always_comb begin
    hit_enc = '0;
    for (int w = 0; w < WAYS; w++)
      if (match[w]) hit_enc = WAY_W'(w);
  end

  assign upd_en    = s1_valid & (s1_fill | (s1_write & ~s1_wt & single));
  assign upd_way   = s1_fill ? s1_way : hit_enc;
  assign upd_dirty = s1_fill ? (s1_write & ~s1_wt) : 1'b1;

  cache_tag_state #(.WAYS(WAYS), .IDX_W(IDX_W)) u_state (
    .clk       (clk),
    .rst       (rst),
    .rd_en     (accept),
    .rd_idx    (idx0),
    .rd_vld    (row_vld),
    .rd_drt    (row_drt),
    .inv_start (inv_start),
    .busy      (busy),
    .upd_en    (upd_en),
    .upd_idx   (s1_idx),
    .upd_way   (upd_way),
    .upd_fill  (s1_fill),
    .upd_dirty (upd_dirty)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_way   <= '0;
      rsp_multi <= 1'b0;
      wb_req    <= 1'b0;
      wb_tag    <= '0;
      wb_index  <= '0;
    end else begin
      rsp_valid <= s1_valid & ~s1_fill;
      rsp_hit   <= s1_valid & ~s1_fill & single;
      rsp_multi <= s1_valid & ~s1_fill & multi;
      rsp_way   <= single ? hit_enc : '0;
      wb_req    <= s1_valid & s1_fill & row_vld[s1_way] & row_drt[s1_way];
      wb_tag    <= way_tag[s1_way];
      wb_index  <= s1_idx;
    end
  end
endmodule

// File: rtl/cache_tag_dir_chk.sv
module cache_tag_dir_chk #(
  parameter int unsigned SETS = 512
)(
  input logic clk,
  input logic rst,
  input logic busy,
  input logic op_valid,
  input logic op_fill,
  input logic rsp_valid,
  input logic rsp_hit,
  input logic rsp_multi,
  input logic wb_req
);
  localparam int unsigned CW = $clog2(SETS) + 2;
  logic [CW-1:0] bcnt;

  always_ff @(posedge clk) begin
    if (rst)       bcnt <= '0;
    else if (busy) bcnt <= bcnt + 1'b1;
    else           bcnt <= '0;
  end

  assert_hit_multi_excl_R4: assert property (@(posedge clk) disable iff (rst)
    rsp_multi |-> !rsp_hit);
  assert_result_in_rsp_R3: assert property (@(posedge clk) disable iff (rst)
    (rsp_hit || rsp_multi) |-> rsp_valid);
  assert_rsp_from_lookup_R3: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $past(op_valid && !op_fill && !busy, 2));
  assert_wb_from_fill_R7: assert property (@(posedge clk) disable iff (rst)
    wb_req |-> $past(op_valid && op_fill && !busy, 2));
  assert_sweep_length_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == CW'(SETS)));
  assert_sweep_bound_R8: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt < CW'(SETS)));
  assert_drop_while_busy_R9: assert property (@(posedge clk) disable iff (rst)
    $past(busy, 2) |-> (!rsp_valid && !wb_req));
endmodule

bind cache_tag_dir cache_tag_dir_chk #(.SETS(1 << IDX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .op_valid  (op_valid),
  .op_fill   (op_fill),
  .rsp_valid (rsp_valid),
  .rsp_hit   (rsp_hit),
  .rsp_multi (rsp_multi),
  .wb_req    (wb_req)
);

// File: tb/cache_tag_dir_bench.sv
module cache_tag_dir_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0, cfg_big = 1'b0, inv_start = 1'b0;
  logic        op_valid = 1'b0, op_fill = 1'b0, op_write = 1'b0, op_wt = 1'b0;
  logic [31:0] op_addr = '0;
  logic [1:0]  op_way = '0;
  logic        busy, rsp_valid, rsp_hit, rsp_multi, wb_req;
  logic [1:0]  rsp_way;
  logic [21:0] wb_tag;
  logic [8:0]  wb_index;

  int checks = 0;
  int errors = 0;

  logic        r_valid, r_hit, r_multi, r_wb;
  logic [1:0]  r_way;
  logic [21:0] r_wbtag;
  logic [8:0]  r_wbidx;

  always #2 clk = ~clk;

  cache_tag_dir u_cache_tag_dir (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_big(cfg_big),
    .inv_start(inv_start), .busy(busy), .op_valid(op_valid),
    .op_fill(op_fill), .op_write(op_write), .op_wt(op_wt),
    .op_addr(op_addr), .op_way(op_way), .rsp_valid(rsp_valid),
    .rsp_hit(rsp_hit), .rsp_way(rsp_way), .rsp_multi(rsp_multi),
    .wb_req(wb_req), .wb_tag(wb_tag), .wb_index(wb_index)
  );

  task automatic chk(input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] a_small(input int s, input int hi);
    return (32'(hi) << 12) | (32'(s) << 4);
  endfunction

  function automatic logic [31:0] a_big(input int s, input int hi);
    return (32'(hi) << 13) | (32'(s) << 4);
  endfunction

  // Called at a falling edge; returns at the falling edge after the result edge.
  task automatic do_op(input logic fill, input logic wr, input logic wt,
                       input logic [31:0] addr, input logic [1:0] way);
    op_valid = 1'b1; op_fill = fill; op_write = wr; op_wt = wt;
    op_addr = addr; op_way = way;
    @(negedge clk);
    op_valid = 1'b0;
    @(negedge clk);
    r_valid = rsp_valid; r_hit = rsp_hit; r_multi = rsp_multi; r_way = rsp_way;
    r_wb = wb_req; r_wbtag = wb_tag; r_wbidx = wb_index;
  endtask

  task automatic set_mode(input logic big);
    cfg_we = 1'b1; cfg_big = big;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic sweep_all(output int n);
    inv_start = 1'b1;
    @(negedge clk);
    inv_start = 1'b0;
    n = 0;
    while (busy && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic [31:0] a, b;
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R2 reset state
    chk("R2", "rsp_valid", rsp_valid, 0);
    chk("R2", "wb_req", wb_req, 0);
    chk("R2", "busy", busy, 0);
    chk("R2", "rsp_hit", rsp_hit, 0);
    do_op(0, 0, 0, a_small(3, 7), 0);
    chk("R3", "lookup rsp_valid", r_valid, 1);
    chk("R2", "miss after reset", r_hit, 0);

    // R10 / R1: default 256-set mode aliases bit 12 onto the same set
    a = 32'h0000_1010; b = 32'h0000_0010;
    do_op(1, 1, 0, a, 0);
    chk("R7", "fill into invalid way wb", r_wb, 0);
    do_op(1, 0, 0, b, 0);
    chk("R10", "small mode alias wb_req", r_wb, 1);
    chk("R7", "wb_tag", r_wbtag, a >> 10);
    chk("R7", "wb_index", r_wbidx, 1);

    // R10: 512-set mode separates them
    sweep_all(n);
    set_mode(1);
    do_op(1, 1, 0, a, 0);
    do_op(1, 0, 0, b, 0);
    chk("R10", "big mode no alias wb_req", r_wb, 0);
    do_op(0, 0, 0, a, 0);
    chk("R1", "big mode hit a", r_hit, 1);
    do_op(0, 0, 0, b, 0);
    chk("R1", "big mode hit b", r_hit, 1);

    // R8 sweep length and clearing
    sweep_all(n);
    chk("R8", "busy cycles", n, 512);
    do_op(0, 0, 0, a, 0);
    chk("R8", "miss after sweep", r_hit, 0);

    // R1 / R3 near-exhaustive sweep, 256-set mode
    set_mode(0);
    for (int s = 0; s < 256; s++)
      for (int w = 0; w < 4; w++) begin
        do_op(1, 0, 0, a_small(s, s * 4 + w + 1), 2'(w));
        chk("R7", "clean fill wb", r_wb, 0);
      end
    for (int s = 0; s < 256; s++) begin
      for (int w = 0; w < 4; w++) begin
        do_op(0, 0, 0, a_small(s, s * 4 + w + 1) | 32'((s + w) & 15), 2'(3 - w));
        chk("R3", "small hit", r_hit, 1);
        chk("R3", "small way", r_way, w);
        chk("R1", "offset ignored multi", r_multi, 0);
      end
      do_op(0, 0, 0, a_small(s, 0), 0);
      chk("R3", "small miss", r_hit, 0);
    end

    // R1 sweep, 512-set mode, one way per set
    sweep_all(n);
    set_mode(1);
    for (int s = 0; s < 512; s++)
      do_op(1, 0, 0, a_big(s, s + 1), 2'(s % 4));
    for (int s = 0; s < 512; s++) begin
      do_op(0, 0, 0, a_big(s, s + 1) | 32'(s & 15), 0);
      chk("R1", "big hit", r_hit, 1);
      chk("R1", "big way", r_way, s % 4);
    end

    // Dirty tracking, 256-set mode
    sweep_all(n);
    set_mode(0);
    do_op(1, 1, 0, a_small(5, 100), 2);
    do_op(1, 0, 0, a_small(5, 101), 2);
    chk("R6", "write-back fill dirty wb_req", r_wb, 1);
    chk("R7", "victim tag", r_wbtag, a_small(5, 100) >> 10);
    chk("R7", "victim index", r_wbidx, 5);
    do_op(1, 0, 0, a_small(5, 102), 2);
    chk("R6", "read fill clean", r_wb, 0);

    do_op(1, 1, 1, a_small(6, 100), 1);
    do_op(1, 0, 0, a_small(6, 101), 1);
    chk("R6", "write-through fill clean", r_wb, 0);

    do_op(1, 0, 0, a_small(7, 100), 3);
    do_op(0, 1, 0, a_small(7, 100), 0);
    chk("R5", "write hit", r_hit, 1);
    do_op(1, 0, 0, a_small(7, 101), 3);
    chk("R5", "write-back hit dirty", r_wb, 1);
    chk("R5", "dirty tag", r_wbtag, a_small(7, 100) >> 10);

    do_op(1, 0, 0, a_small(8, 100), 0);
    do_op(0, 0, 0, a_small(8, 100), 0);
    do_op(0, 1, 1, a_small(8, 100), 0);
    chk("R5", "write-through hit", r_hit, 1);
    do_op(1, 0, 0, a_small(8, 101), 0);
    chk("R5", "read and write-through hits stay clean", r_wb, 0);

    // R4 multiple match
    do_op(1, 0, 0, a_small(9, 100), 0);
    do_op(1, 0, 0, a_small(9, 100), 1);
    do_op(0, 0, 0, a_small(9, 100), 0);
    chk("R4", "multi flag", r_multi, 1);
    chk("R4", "no hit on multi", r_hit, 0);
    chk("R4", "multi rsp_valid", r_valid, 1);

    // R9 operations during sweep are dropped; R8 clears dirty
    do_op(1, 1, 0, a_small(10, 100), 0);
    inv_start = 1'b1;
    @(negedge clk);
    inv_start = 1'b0;
    repeat (100) @(negedge clk);
    op_valid = 1'b1; op_fill = 1'b1; op_write = 1'b1; op_wt = 1'b0;
    op_addr = a_small(0, 55); op_way = 0;
    @(negedge clk);
    op_fill = 1'b0;
    @(negedge clk);
    op_valid = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R9", "no rsp during sweep", rsp_valid, 0);
      chk("R9", "no wb during sweep", wb_req, 0);
      @(negedge clk);
    end
    while (busy) @(negedge clk);
    do_op(0, 0, 0, a_small(0, 55), 0);
    chk("R9", "dropped fill left no entry", r_hit, 0);
    do_op(1, 0, 0, a_small(10, 101), 0);
    chk("R8", "sweep cleared dirty", r_wb, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule